// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This unit sits beside a five-stage in-order integer pipeline and decides, each cycle, whether the front end advances, holds or is wiped, and where each execute-stage operand comes from. It watches the valid bit, destination register, register-write flag and load flag of the instructions in decode, execute, memory access and write-back. It also sees the source registers read in decode and in execute, and the taken-redirect request and target address produced in execute. The unit holds the fetch address register itself. That register advances by one word per cycle unless the unit holds it or reloads it with a redirect target.

Control transfers are resolved in execute, and the unit predicts them not-taken. A taken transfer therefore wipes the two younger instructions in fetch and decode, which costs two empty slots. A load in execute that feeds an instruction in decode holds fetch and decode for one cycle and sends one empty slot into execute. Results still in flight reach execute over two bypass paths, from the memory stage or the write-back stage. The write-back stage also bypasses into decode, so a value written and read in the same cycle needs no extra wait.

Top module: `hazard_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, `pc_q` is loaded with the `RESET_PC` parameter (default 0). With an idle pipeline, `pc_we` and `ifid_we` are 1 and `ifid_flush`, `idex_flush` and `idex_bubble` are 0.
- R2: With no redirect and no load-use hazard, `pc_q` grows by 4 on every rising edge, `pc_we` and `ifid_we` are 1, and no flush or bubble output is raised.
- R3: When `ex_valid` and `ex_redirect` are both 1, `ifid_flush` and `idex_flush` are 1 in that cycle and `pc_q` equals `ex_target` after the next edge. A replayed taken transfer costs exactly two empty write-back slots.
- R4: A load-use hazard exists when the execute instruction is valid, is a load, writes a register, and its nonzero `ex_rd` equals `id_rs1` or `id_rs2` of a valid decode instruction. In that cycle `idex_bubble` is 1, `pc_we` and `ifid_we` are 0, and `pc_q` keeps its value over the edge. A replayed load-use pair costs exactly one empty slot.
- R5: Register number 0 never creates a dependency. A zero destination causes no stall, forward or decode bypass.
- R6: A redirect takes priority over a load-use hazard in the same cycle. `idex_bubble` stays 0, `pc_we` and `ifid_we` stay 1, both flush outputs are 1, and `pc_q` takes the target.
- R7: `fwd_a` selects for `ex_rs1` and `fwd_b` selects for `ex_rs2`, with the codes 2'b00 register file, 2'b01 write-back stage, 2'b10 memory stage. When both stages match, the memory stage (newer) is chosen.
- R8: A load in the memory stage is never a forwarding source (code 2'b10 is not produced for it). The write-back stage may still match.
- R9: A stage with valid 0, or with its register-write flag 0, raises no stall, forward or bypass.
- R10: `id_wb_byp_a` (or `id_wb_byp_b`) is 1 when a valid, register-writing write-back instruction has a nonzero destination equal to `id_rs1` (or `id_rs2`).
- R11: A load whose consumer is a taken branch costs one stall slot plus two redirect slots, three empty slots in all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs1 | input | 5 | Decode first source register |
| id_rs2 | input | 5 | Decode second source register |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_rd | input | 5 | Execute destination register |
| ex_reg_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_rs1 | input | 5 | Execute first source register |
| ex_rs2 | input | 5 | Execute second source register |
| ex_redirect | input | 1 | Execute resolved a taken branch or jump |
| ex_target | input | 32 | Redirect target address |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_rd | input | 5 | Memory stage destination register |
| mem_reg_we | input | 1 | Memory stage instruction writes a register |
| mem_is_load | input | 1 | Memory stage instruction is a load |
| wb_valid | input | 1 | Write-back stage holds a real instruction |
| wb_rd | input | 5 | Write-back destination register |
| wb_reg_we | input | 1 | Write-back instruction writes a register |
| pc_q | output | 32 | Current fetch address |
| pc_we | output | 1 | Fetch address may advance |
| ifid_we | output | 1 | Fetch/decode register may load |
| ifid_flush | output | 1 | Fetch/decode register loads an empty slot |
| idex_bubble | output | 1 | Decode/execute register loads an empty slot for a load-use stall |
| idex_flush | output | 1 | Decode/execute register loads an empty slot for a redirect |
| fwd_a | output | 2 | Source select for first execute operand |
| fwd_b | output | 2 | Source select for second execute operand |
| id_wb_byp_a | output | 1 | Decode first source takes the write-back value |
| id_wb_byp_b | output | 1 | Decode second source takes the write-back value |

## Verification
The bench goes after the same-cycle clash of a redirect with a load-use hazard. A design that lets the stall win would freeze the fetch address and keep a wrong-path instruction alive instead of jumping. It also checks that a load sitting in the memory stage is skipped as a bypass source, since a design that forwards it hands execute an address instead of the loaded data. Register 0 as destination, empty or non-writing stages, and the newer-wins rule are checked too; a design that gets any of these wrong stalls or forwards where nothing depends. Short replayed programs run through a cycle-level stage model, and the bench counts the empty slots between retirements: one for a load-use pair, two for a taken transfer, three for a load feeding a taken branch.

// File: rtl/hzd_pkg.sv
// Shared types for the hazard control unit.
// Assumes a 2-bit operand select in the execute stage datapath.
package hzd_pkg;
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/hzd_loaduse.sv
// Load-use detector: flags a valid load in execute whose nonzero destination
// feeds a source of the valid decode instruction.
// Assumes the source numbers of an unused operand are 0.
module hzd_loaduse #(
    parameter int REG_AW = 5,
    parameter int NSRC   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         id_valid,
    input  logic [NSRC-1:0][REG_AW-1:0]  id_rs,
    input  logic                         ex_valid,
    input  logic                         ex_is_load,
    input  logic                         ex_reg_we,
    input  logic [REG_AW-1:0]            ex_rd,
    output logic                         load_use
);
    logic [NSRC-1:0] src_hit;
    logic            ex_produces;

    // Execute holds a load that will write a real register.
    assign ex_produces = ex_valid && ex_is_load && ex_reg_we && (ex_rd != '0);

    // One comparator per decode source.
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign src_hit[s] = (id_rs[s] == ex_rd);
    end

    // Any matching source of a valid decode instruction stalls.
    assign load_use = id_valid && ex_produces && (|src_hit);

    p_empty_ex_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |-> !load_use);
    p_zero_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == '0) |-> !load_use);
endmodule

// File: rtl/hzd_fwd_sel.sv
// Operand source select for one execute operand: memory stage first (newer),
// then write-back, else register file. Loads in the memory stage are skipped
// because their data is not ready until write-back.
module hzd_fwd_sel
    import hzd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] rs,
    input  logic              mem_valid,
    input  logic              mem_reg_we,
    input  logic              mem_is_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              wb_valid,
    input  logic              wb_reg_we,
    input  logic [REG_AW-1:0] wb_rd,
    output fwd_sel_e          sel
);
    logic mem_hit, wb_hit;

    // Match against a non-load ALU result waiting in the memory stage.
    assign mem_hit = mem_valid && mem_reg_we && !mem_is_load &&
                     (mem_rd != '0) && (mem_rd == rs);
    // Match against the value being written back.
    assign wb_hit  = wb_valid && wb_reg_we && (wb_rd != '0) && (wb_rd == rs);

    // Priority pick, newest producer first.
    always_comb begin
        if (mem_hit)     sel = FWD_MEM;
        else if (wb_hit) sel = FWD_WB;
        else             sel = FWD_RF;
    end

    p_no_load_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_is_load) |-> (sel != FWD_MEM));
    p_wb_src_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == FWD_WB) |-> (wb_valid && wb_reg_we && wb_rd == rs && rs != '0));
endmodule

// File: rtl/hzd_pc_ctl.sv
// Fetch address register and front-end steering. A redirect reloads the
// address and wipes fetch and decode; otherwise a load-use hazard holds
// fetch and decode and inserts one empty slot into execute.
module hzd_pc_ctl #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect,
    input  logic [XLEN-1:0] target,
    input  logic            load_use,
    output logic [XLEN-1:0] pc_q,
    output logic            pc_we,
    output logic            ifid_we,
    output logic            ifid_flush,
    output logic            idex_bubble,
    output logic            idex_flush
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);
    logic stall;

    // Redirect overrides the stall.
    assign stall       = load_use && !redirect;
    assign pc_we       = !stall;
    assign ifid_we     = !stall;
    assign idex_bubble = stall;
    assign ifid_flush  = redirect;
    assign idex_flush  = redirect;

    // Fetch address update: reset, redirect, advance or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc_q <= RESET_PC;
        else if (redirect) pc_q <= target;
        else if (pc_we)    pc_q <= pc_q + STEP;
    end

    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && !load_use) |=> (pc_q == $past(pc_q) + STEP));
    p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (pc_q == $past(target)));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_use && !redirect) |=> $stable(pc_q));
    p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && load_use) |-> (!idex_bubble && ifid_we && idex_flush));
endmodule

// File: rtl/hazard_ctrl.sv
// Hazard control for a five-stage in-order pipeline: stall, squash,
// execute-operand forwarding and write-back-to-decode bypass.
// Assumes control transfers resolve in execute and fetch predicts not-taken.
module hazard_ctrl
    import hzd_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              REG_AW   = 5,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              ex_valid,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_reg_we,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic              ex_redirect,
    input  logic [XLEN-1:0]   ex_target,
    input  logic              mem_valid,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_reg_we,
    input  logic              mem_is_load,
    input  logic              wb_valid,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_reg_we,
    output logic [XLEN-1:0]   pc_q,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              ifid_flush,
    output logic              idex_bubble,
    output logic              idex_flush,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic              id_wb_byp_a,
    output logic              id_wb_byp_b
);
    localparam int NOPS = 2;

    logic                       load_use;
    logic                       redirect;
    logic [NOPS-1:0][REG_AW-1:0] id_src;
    logic [NOPS-1:0][REG_AW-1:0] ex_src;
    fwd_sel_e [NOPS-1:0]         sel;
    logic [NOPS-1:0]             byp;
    logic                        wb_produces;

    assign id_src   = {id_rs2, id_rs1};
    assign ex_src   = {ex_rs2, ex_rs1};
    assign redirect = ex_valid && ex_redirect;

    hzd_loaduse #(.REG_AW(REG_AW), .NSRC(NOPS)) u_loaduse (
        .clk(clk), .rst_n(rst_n),
        .id_valid(id_valid), .id_rs(id_src),
        .ex_valid(ex_valid), .ex_is_load(ex_is_load),
        .ex_reg_we(ex_reg_we), .ex_rd(ex_rd),
        .load_use(load_use)
    );

    hzd_pc_ctl #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc_ctl (
        .clk(clk), .rst_n(rst_n),
        .redirect(redirect), .target(ex_target), .load_use(load_use),
        .pc_q(pc_q), .pc_we(pc_we), .ifid_we(ifid_we),
        .ifid_flush(ifid_flush), .idex_bubble(idex_bubble),
        .idex_flush(idex_flush)
    );

    // Write-back holds a real register result.
    assign wb_produces = wb_valid && wb_reg_we && (wb_rd != '0);

    // Per-operand forwarding select and decode bypass.
    for (genvar k = 0; k < NOPS; k++) begin : g_op
        hzd_fwd_sel #(.REG_AW(REG_AW)) u_fwd (
            .clk(clk), .rst_n(rst_n), .rs(ex_src[k]),
            .mem_valid(mem_valid), .mem_reg_we(mem_reg_we),
            .mem_is_load(mem_is_load), .mem_rd(mem_rd),
            .wb_valid(wb_valid), .wb_reg_we(wb_reg_we), .wb_rd(wb_rd),
            .sel(sel[k])
        );
        assign byp[k] = wb_produces && (wb_rd == id_src[k]);
    end

    assign fwd_a       = sel[0];
    assign fwd_b       = sel[1];
    assign id_wb_byp_a = byp[0];
    assign id_wb_byp_b = byp[1];

    p_byp_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (id_wb_byp_a || id_wb_byp_b) |-> (wb_valid && wb_reg_we && wb_rd != '0));
    p_x0_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == '0 && !redirect) |-> (pc_we && !idex_bubble));
    p_squash_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_redirect) |-> (ifid_flush && idex_flush));
endmodule

// File: tb/hazard_ctrl_tb_top.sv
`timescale 1ns/1ps
module hazard_ctrl_tb_top;
    typedef struct packed {
        logic       v;
        logic [7:0] id;
        logic [4:0] rd;
        logic [4:0] rs1;
        logic [4:0] rs2;
        logic       ld;
        logic       we;
        logic       br;
        logic [3:0] tgt;
    } ins_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    ins_t s_id = '0, s_ex = '0, s_mem = '0, s_wb = '0;

    logic [31:0] pc_q;
    logic pc_we, ifid_we, ifid_flush, idex_bubble, idex_flush;
    logic [1:0] fwd_a, fwd_b;
    logic id_wb_byp_a, id_wb_byp_b;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    hazard_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .id_valid(s_id.v), .id_rs1(s_id.rs1), .id_rs2(s_id.rs2),
        .ex_valid(s_ex.v), .ex_rd(s_ex.rd), .ex_reg_we(s_ex.we),
        .ex_is_load(s_ex.ld), .ex_rs1(s_ex.rs1), .ex_rs2(s_ex.rs2),
        .ex_redirect(s_ex.br), .ex_target({26'd0, s_ex.tgt, 2'b00}),
        .mem_valid(s_mem.v), .mem_rd(s_mem.rd), .mem_reg_we(s_mem.we),
        .mem_is_load(s_mem.ld),
        .wb_valid(s_wb.v), .wb_rd(s_wb.rd), .wb_reg_we(s_wb.we),
        .pc_q(pc_q), .pc_we(pc_we), .ifid_we(ifid_we), .ifid_flush(ifid_flush),
        .idex_bubble(idex_bubble), .idex_flush(idex_flush),
        .fwd_a(fwd_a), .fwd_b(fwd_b),
        .id_wb_byp_a(id_wb_byp_a), .id_wb_byp_b(id_wb_byp_b)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic ins_t mk(input int id, input int rd, input int rs1,
                                input int rs2, input bit ld, input bit br,
                                input int tgt);
        ins_t r;
        r.v = 1'b1; r.id = 8'(id); r.rd = 5'(rd); r.rs1 = 5'(rs1);
        r.rs2 = 5'(rs2); r.ld = ld; r.we = (rd != 0); r.br = br;
        r.tgt = 4'(tgt);
        return r;
    endfunction

    task automatic clear_stages();
        s_id = '0; s_ex = '0; s_mem = '0; s_wb = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_stages();
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: reset value and idle controls
    task automatic t_reset();
        do_reset();
        #1;
        chk(pc_q == 32'd0, "R1 pc after reset", pc_q, 0);
        chk({pc_we, ifid_we, ifid_flush, idex_flush, idex_bubble} == 5'b11000,
            "R1 idle controls", {pc_we, ifid_we, ifid_flush, idex_flush, idex_bubble}, 5'b11000);
    endtask

    // R2: free-running advance by 4
    task automatic t_advance();
        logic [31:0] p0;
        @(negedge clk); clear_stages(); p0 = pc_q;
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            chk(pc_q == p0 + 32'(4*i), "R2 pc advance", pc_q, p0 + 32'(4*i));
        end
    endtask

    // R4: load-use stall through either source
    task automatic t_loaduse(input bit use_rs2);
        logic [31:0] p0;
        @(negedge clk);
        clear_stages();
        s_ex = mk(1, 7, 0, 0, 1, 0, 0);
        s_id = use_rs2 ? mk(2, 8, 3, 7, 0, 0, 0) : mk(2, 8, 7, 3, 0, 0, 0);
        #1; p0 = pc_q;
        chk({idex_bubble, pc_we, ifid_we, idex_flush} == 4'b1000, "R4 stall controls",
            {idex_bubble, pc_we, ifid_we, idex_flush}, 4'b1000);
        @(negedge clk);
        chk(pc_q == p0, "R4 pc held", pc_q, p0);
        clear_stages();
    endtask

    // R5: register 0 creates no dependency
    task automatic t_x0();
        @(negedge clk);
        clear_stages();
        s_ex = mk(1, 0, 0, 0, 1, 0, 0); s_ex.we = 1'b1;
        s_id = mk(2, 4, 0, 0, 0, 0, 0);
        s_mem = mk(3, 0, 0, 0, 0, 0, 0); s_mem.we = 1'b1;
        s_wb = mk(4, 0, 0, 0, 0, 0, 0); s_wb.we = 1'b1;
        #1;
        chk(!idex_bubble && pc_we, "R5 no stall on x0", {idex_bubble, pc_we}, 2'b01);
        chk(fwd_a == 2'b00 && fwd_b == 2'b00, "R5 no forward on x0", {fwd_a, fwd_b}, 0);
        chk(!id_wb_byp_a && !id_wb_byp_b, "R5 no bypass on x0", {id_wb_byp_a, id_wb_byp_b}, 0);
    endtask

    // R9: empty or non-writing stages are inert
    task automatic t_inert();
        @(negedge clk);
        clear_stages();
        s_ex = mk(1, 6, 0, 0, 1, 0, 0); s_ex.v = 1'b0;
        s_id = mk(2, 8, 6, 0, 0, 0, 0);
        #1;
        chk(!idex_bubble && pc_we, "R9 empty ex no stall", idex_bubble, 0);
        s_ex = mk(1, 9, 6, 6, 0, 0, 0);
        s_mem = mk(3, 6, 0, 0, 0, 0, 0); s_mem.v = 1'b0;
        s_wb = mk(4, 6, 0, 0, 0, 0, 0); s_wb.we = 1'b0;
        #1;
        chk(fwd_a == 2'b00 && fwd_b == 2'b00, "R9 no forward from inert stages",
            {fwd_a, fwd_b}, 0);
        chk(!id_wb_byp_a, "R9 no bypass from non-writing wb", id_wb_byp_a, 0);
    endtask

    // R7: forwarding codes and newer-wins
    task automatic t_fwd();
        @(negedge clk);
        clear_stages();
        s_ex = mk(1, 9, 3, 4, 0, 0, 0);
        s_mem = mk(2, 3, 0, 0, 0, 0, 0);
        s_wb = mk(3, 4, 0, 0, 0, 0, 0);
        #1;
        chk(fwd_a == 2'b10, "R7 fwd_a from mem", fwd_a, 2'b10);
        chk(fwd_b == 2'b01, "R7 fwd_b from wb", fwd_b, 2'b01);
        s_wb = mk(3, 3, 0, 0, 0, 0, 0);
        #1;
        chk(fwd_a == 2'b10, "R7 newer mem wins", fwd_a, 2'b10);
        chk(fwd_b == 2'b00, "R7 fwd_b register file", fwd_b, 2'b00);
    endtask

    // R8: loads in the memory stage are not forwarded
    task automatic t_loadfwd();
        @(negedge clk);
        clear_stages();
        s_ex = mk(1, 9, 3, 0, 0, 0, 0);
        s_mem = mk(2, 3, 0, 0, 1, 0, 0);
        #1;
        chk(fwd_a == 2'b00, "R8 load in mem not forwarded", fwd_a, 2'b00);
        s_wb = mk(3, 3, 0, 0, 0, 0, 0);
        #1;
        chk(fwd_a == 2'b01, "R8 falls back to wb", fwd_a, 2'b01);
    endtask

    // R3: redirect squashes and reloads
    task automatic t_redirect();
        @(negedge clk);
        clear_stages();
        s_ex = mk(1, 0, 0, 0, 0, 1, 11);
        #1;
        chk(ifid_flush && idex_flush && !idex_bubble, "R3 flush controls",
            {ifid_flush, idex_flush, idex_bubble}, 3'b110);
        @(negedge clk);
        chk(pc_q == 32'd44, "R3 pc takes target", pc_q, 44);
        clear_stages();
    endtask

    // R6: redirect beats same-cycle load-use
    task automatic t_prio();
        @(negedge clk);
        clear_stages();
        s_ex = mk(1, 5, 0, 0, 1, 1, 6);
        s_id = mk(2, 8, 5, 0, 0, 0, 0);
        #1;
        chk({idex_bubble, pc_we, ifid_we, ifid_flush, idex_flush} == 5'b01111,
            "R6 redirect over stall", {idex_bubble, pc_we, ifid_we, ifid_flush, idex_flush}, 5'b01111);
        @(negedge clk);
        chk(pc_q == 32'd24, "R6 pc takes target", pc_q, 24);
        clear_stages();
    endtask

    // R10: write-back to decode bypass
    task automatic t_byp();
        @(negedge clk);
        clear_stages();
        s_wb = mk(1, 9, 0, 0, 0, 0, 0);
        s_id = mk(2, 4, 3, 9, 0, 0, 0);
        #1;
        chk(!id_wb_byp_a && id_wb_byp_b, "R10 bypass on rs2 only",
            {id_wb_byp_a, id_wb_byp_b}, 2'b01);
    endtask

    // Replay model: program, expected retirement ids and empty-slot count.
    ins_t prog[8];
    int   plen;
    int   exp_ids[8];
    int   exp_n;

    task automatic run_prog(input string req, input int exp_bub);
        int ret_id[16];
        int ret_cyc[16];
        int nret = 0;
        ins_t fetched, n_id, n_ex, n_mem, n_wb;
        int idx;
        do_reset();
        for (int c = 0; c < 24; c++) begin
            if (c > 0) @(negedge clk);
            if (s_wb.v && nret < 16) begin
                ret_id[nret] = int'(s_wb.id); ret_cyc[nret] = c; nret++;
            end
            idx = int'(pc_q >> 2);
            fetched = (idx < plen) ? prog[idx] : '0;
            n_wb = s_mem;
            n_mem = s_ex;
            n_ex = (idex_flush || idex_bubble) ? '0 : s_id;
            n_id = ifid_flush ? '0 : (ifid_we ? fetched : s_id);
            @(posedge clk); #1;
            s_wb = n_wb; s_mem = n_mem; s_ex = n_ex; s_id = n_id;
        end
        chk(nret == exp_n, {req, " retire count"}, nret, exp_n);
        for (int k = 0; k < exp_n && k < nret; k++)
            chk(ret_id[k] == exp_ids[k], {req, " retire order"}, ret_id[k], exp_ids[k]);
        if (nret > 0)
            chk((ret_cyc[nret-1] - ret_cyc[0] + 1 - nret) == exp_bub, {req, " empty slots"},
                ret_cyc[nret-1] - ret_cyc[0] + 1 - nret, exp_bub);
        @(negedge clk); clear_stages();
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_advance();
        t_loaduse(1'b0);
        t_loaduse(1'b1);
        t_x0();
        t_inert();
        t_fwd();
        t_loadfwd();
        t_redirect();
        t_prio();
        t_byp();

        // R4: load then dependent add, one empty slot
        prog[0] = mk(0, 5, 1, 0, 1, 0, 0);
        prog[1] = mk(1, 6, 5, 2, 0, 0, 0);
        prog[2] = mk(2, 7, 1, 2, 0, 0, 0);
        prog[3] = mk(3, 8, 1, 2, 0, 0, 0);
        plen = 4; exp_n = 4;
        exp_ids[0] = 0; exp_ids[1] = 1; exp_ids[2] = 2; exp_ids[3] = 3;
        run_prog("R4 replay load-use", 1);

        // R3: taken jump to slot 4, two wrong-path slots wiped
        prog[0] = mk(0, 5, 1, 0, 0, 0, 0);
        prog[1] = mk(1, 0, 0, 0, 0, 1, 4);
        prog[2] = mk(2, 6, 1, 0, 0, 0, 0);
        prog[3] = mk(3, 7, 1, 0, 0, 0, 0);
        prog[4] = mk(4, 8, 1, 0, 0, 0, 0);
        prog[5] = mk(5, 9, 1, 0, 0, 0, 0);
        plen = 6; exp_n = 4;
        exp_ids[0] = 0; exp_ids[1] = 1; exp_ids[2] = 4; exp_ids[3] = 5;
        run_prog("R3 replay jump", 2);

        // R11: load feeding a taken branch, stall then redirect
        prog[0] = mk(0, 6, 1, 0, 1, 0, 0);
        prog[1] = mk(1, 0, 6, 0, 0, 1, 5);
        prog[2] = mk(2, 7, 1, 0, 0, 0, 0);
        prog[3] = mk(3, 8, 1, 0, 0, 0, 0);
        prog[4] = mk(4, 9, 1, 0, 0, 0, 0);
        prog[5] = mk(5, 10, 1, 0, 0, 0, 0);
        plen = 6; exp_n = 3;
        exp_ids[0] = 0; exp_ids[1] = 1; exp_ids[2] = 5;
        run_prog("R11 replay load-branch", 3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule